// File: doc/BRIEF.md
# Page-mode read hit controller

This block sits in front of an external memory read path. For every read request it decides whether the word lies in the page that is currently open, and it reports how many clock cycles the read will take. A page hit costs the programmed intra-page access time. A miss costs the full random-access latency, which arrives as a plain input, and it opens a new page at the requested address.

A page stays usable only for a programmable number of clock edges after it was opened. An optional mode accepts as hits only strictly sequential word addresses. A single configuration word holds the page size, the hit rule, the hit access time and the open window. Requests use a valid/ready handshake. A one-cycle done strobe marks the end of each read, and the hit flag and wait count are valid with it.

Top module: `pgrd_ctrl`

## Requirements
- R1: After reset, cfg_q reads 0x0000_0F00 (hit time code 15, window 0, any-word rule, 4-word pages), req_ready is 1 and rsp_done is 0.
- R2: A write through cfg_we stores only these fields: window limit in bits [23:16], hit time code in bits [11:8], sequential-rule bit in bit 4 and page-size code in bits [1:0]. All other bits of cfg_q read as 0.
- R3: Page-size code n gives pages of 4<<n words (00=4, 01=8, 10=16, 11=32). Two word addresses share a page when they differ only in their low 2+n bits. When bit 4 is 0, any word of the open page can hit.
- R4: When bit 4 is 1, a request hits only if its address equals the previously accepted address plus one and both lie in the same open page.
- R5: A hit reports a wait of the hit time code, except that codes 0 and 1 both give 1 cycle.
- R6: A miss reports a wait equal to miss_lat, except that a value of 0 gives 1 cycle.
- R7: A request can hit only if it is accepted no more than L clock edges after the edge that opened the page, where L is the window limit.
- R8: A window limit of 0, or page_en low at acceptance, makes every request a miss. Such a miss opens no page.
- R9: A configuration write closes the open page, so the next request is a miss.
- R10: req_ready is high only while no read is in progress. rsp_done is a single-cycle pulse in the W-th cycle after the accepting edge, where W is the reported wait. rsp_hit and rsp_wait are valid during that pulse.
- R11: A miss opens a new page at its address and restarts the window. A hit does not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_q | output | 32 | Stored configuration word |
| page_en | input | 1 | Global enable for page reads |
| miss_lat | input | LAT_W | Full random-access latency in cycles |
| req_valid | input | 1 | Read request valid |
| req_addr | input | ADDR_W | Word address of the read |
| req_ready | output | 1 | Block can accept a request |
| rsp_done | output | 1 | One-cycle end-of-read strobe |
| rsp_hit | output | 1 | Last accepted read was a page hit |
| rsp_wait | output | LAT_W | Cycle count of the last accepted read |

## Verification
The bench builds the block with ADDR_W=10 and LAT_W=5. The narrow address space keeps random addresses close to the open page, so hits, page-boundary misses and sequential runs all occur often. The 5-bit latency keeps miss waits short enough for several hundred reads and still reaches the zero-latency clamp and the 31-cycle maximum. Directed sequences place requests just inside and just outside the open window and across page edges for all four page sizes.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

  localparam int unsigned LIM_W  = 8;
  localparam int unsigned TIME_W = 4;
  localparam int unsigned SIZE_W = 2;
  localparam int unsigned OFS_BASE = 2;
  localparam int unsigned OFS_MAX  = OFS_BASE + (1 << SIZE_W) - 1;

  localparam logic [31:0] CFG_RESET = 32'h0000_0F00;

  typedef struct packed {
    logic [LIM_W-1:0]  win_lim;
    logic [TIME_W-1:0] hit_time;
    logic              seq_only;
    logic [SIZE_W-1:0] pg_size;
  } pg_cfg_t;

  function automatic pg_cfg_t cfg_from_word(input logic [31:0] w);
    pg_cfg_t c;
    c.win_lim  = w[23:16];
    c.hit_time = w[11:8];
    c.seq_only = w[4];
    c.pg_size  = w[1:0];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input pg_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[23:16] = c.win_lim;
    w[11:8]  = c.hit_time;
    w[4]     = c.seq_only;
    w[1:0]   = c.pg_size;
    return w;
  endfunction

endpackage

// File: rtl/pgrd_cfg.sv
module pgrd_cfg
  import pgrd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output pg_cfg_t     cfg,
  output logic [31:0] cfg_word
);

  pg_cfg_t cfg_q;
  pg_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = cfg_from_word(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= cfg_from_word(CFG_RESET);
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg      = cfg_q;
  assign cfg_word = cfg_to_word(cfg_q);

endmodule

// File: rtl/pgrd_page.sv
module pgrd_page
  import pgrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIM_W-1:0]  win_lim,
  input  logic              seq_only,
  input  logic [SIZE_W-1:0] pg_size,
  input  logic              page_en,
  input  logic              cfg_chg,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam int unsigned OFS_W = $clog2(OFS_MAX + 2);

  logic              open_q, open_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic [LIM_W-1:0]  age_q, age_d;
  logic [ADDR_W-1:0] tag_mask;
  logic              en_eff, in_win, same_pg, is_next;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    if (i <= OFS_MAX) begin : g_ofs
      assign tag_mask[i] = (OFS_W'(i) >= (OFS_W'(OFS_BASE) + OFS_W'(pg_size)));
    end else begin : g_tag
      assign tag_mask[i] = 1'b1;
    end
  end

  assign en_eff  = page_en && (win_lim != '0);
  assign in_win  = open_q && (age_q < win_lim);
  assign same_pg = ((addr ^ last_q) & tag_mask) == '0;
  assign is_next = (addr == last_q + ADDR_W'(1));
  assign hit     = en_eff && in_win && same_pg && (!seq_only || is_next);

  always_comb begin
    open_d = open_q;
    last_d = last_q;
    age_d  = age_q;
    if (open_q && (age_q < win_lim)) age_d = age_q + LIM_W'(1);
    if (take) begin
      last_d = addr;
      if (!hit) begin
        open_d = en_eff;
        age_d  = '0;
      end
    end
    if (cfg_chg || !en_eff) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      last_q <= '0;
      age_q  <= '0;
    end else begin
      open_q <= open_d;
      if (take) last_q <= last_d;
      age_q <= age_d;
    end
  end

endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq
  import pgrd_pkg::*;
#(
  parameter int unsigned LAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              take,
  input  logic              hit,
  input  logic [TIME_W-1:0] hit_time,
  input  logic [LAT_W-1:0]  miss_lat,
  output logic              rsp_done,
  output logic              rsp_hit,
  output logic [LAT_W-1:0]  rsp_wait
);

  logic             busy_q, busy_d;
  logic [LAT_W-1:0] rem_q, rem_d;
  logic             hit_q;
  logic [LAT_W-1:0] wait_q;
  logic [LAT_W-1:0] hit_cyc, miss_cyc, wait_sel;

  assign hit_cyc  = (hit_time < TIME_W'(2)) ? LAT_W'(1) : LAT_W'(hit_time);
  assign miss_cyc = (miss_lat == '0) ? LAT_W'(1) : miss_lat;
  assign wait_sel = hit ? hit_cyc : miss_cyc;

  assign req_ready = !busy_q;
  assign take      = req_valid && !busy_q;
  assign rsp_done  = busy_q && (rem_q == '0);

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    if (take) begin
      busy_d = 1'b1;
      rem_d  = wait_sel - LAT_W'(1);
    end else if (busy_q) begin
      if (rem_q == '0) busy_d = 1'b0;
      else rem_d = rem_q - LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      hit_q  <= 1'b0;
      wait_q <= '0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      if (take) begin
        hit_q  <= hit;
        wait_q <= wait_sel;
      end
    end
  end

  assign rsp_hit  = hit_q;
  assign rsp_wait = wait_q;

endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl
  import pgrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_q,
  input  logic              page_en,
  input  logic [LAT_W-1:0]  miss_lat,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_hit,
  output logic [LAT_W-1:0]  rsp_wait
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  pg_cfg_t    cfg;
  logic       take;
  logic       hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pgrd_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .cfg      (cfg),
    .cfg_word (cfg_q)
  );

  pgrd_page #(.ADDR_W(ADDR_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .win_lim  (cfg.win_lim),
    .seq_only (cfg.seq_only),
    .pg_size  (cfg.pg_size),
    .page_en  (page_en),
    .cfg_chg  (cfg_we),
    .take     (take),
    .addr     (req_addr),
    .hit      (hit)
  );

  pgrd_seq #(.LAT_W(LAT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .take      (take),
    .hit       (hit),
    .hit_time  (cfg.hit_time),
    .miss_lat  (miss_lat),
    .rsp_done  (rsp_done),
    .rsp_hit   (rsp_hit),
    .rsp_wait  (rsp_wait)
  );

endmodule

// File: rtl/pgrd_chk.sv
module pgrd_chk #(
  parameter int unsigned LAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [31:0]      cfg_q,
  input logic             page_en,
  input logic [LAT_W-1:0] miss_lat,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_done,
  input logic             rsp_hit,
  input logic [LAT_W-1:0] rsp_wait
);

  logic acc;
  logic we_d;
  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_d <= 1'b0;
    else we_d <= cfg_we;
  end

  // R10: acceptance makes the block busy
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R8: disabled page mode never hits
  a_r8_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (!page_en || cfg_q[23:16] == 8'h00)) |=> !rsp_hit);

  // R6: miss wait follows the latency input with zero clamped to one
  a_r6_miss_wait: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (rsp_hit || rsp_wait == (($past(miss_lat) == '0) ? LAT_W'(1) : $past(miss_lat))));

  // R5: hit wait follows the time code with codes 0 and 1 giving one
  a_r5_hit_wait: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!rsp_hit || rsp_wait == (($past(cfg_q[11:8]) < 4'd2) ? LAT_W'(1) : LAT_W'($past(cfg_q[11:8])))));

  // R9: first request after a configuration write misses
  a_r9_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (we_d && acc) |=> !rsp_hit);

endmodule

bind pgrd_ctrl pgrd_chk #(.LAT_W(LAT_W)) u_pgrd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_q     (cfg_q),
  .page_en   (page_en),
  .miss_lat  (miss_lat),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_hit   (rsp_hit),
  .rsp_wait  (rsp_wait)
);

// File: tb/test_pgrd_ctrl.sv
module test_pgrd_ctrl;

  localparam int unsigned ADDR_W = 10;
  localparam int unsigned LAT_W  = 5;
  localparam time CLK_PERIOD = 10ns;

  logic              clk;
  logic              rst_n;
  logic              cfg_we;
  logic [31:0]       cfg_wdata;
  logic [31:0]       cfg_q;
  logic              page_en;
  logic [LAT_W-1:0]  miss_lat;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready;
  logic              rsp_done;
  logic              rsp_hit;
  logic [LAT_W-1:0]  rsp_wait;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ended = 0;

  // bench model of the configuration and the open page
  int unsigned       m_lim, m_time, m_seq, m_size;
  bit                m_open;
  logic [ADDR_W-1:0] m_last;
  int                m_open_cyc;

  pgrd_ctrl #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) i_pgrd_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .page_en(page_en), .miss_lat(miss_lat), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_hit(rsp_hit), .rsp_wait(rsp_wait)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic bit model_hit(input logic [ADDR_W-1:0] a, input bit en, input int acc_cyc);
    logic [ADDR_W-1:0] msk;
    logic [ADDR_W-1:0] nxt;
    msk = ~((ADDR_W'(4) << m_size) - ADDR_W'(1));
    nxt = m_last + ADDR_W'(1);
    if (!en || m_lim == 0 || !m_open) return 1'b0;
    if ((acc_cyc - m_open_cyc) > int'(m_lim)) return 1'b0;
    if (((a ^ m_last) & msk) != '0) return 1'b0;
    if (m_seq != 0 && a != nxt) return 1'b0;
    return 1'b1;
  endfunction

  task automatic wr_cfg(input int unsigned lim, input int unsigned tm, input int unsigned sq,
                        input int unsigned sz);
    logic [31:0] w;
    logic [31:0] e;
    w = $urandom();
    w[23:16] = lim[7:0];
    w[11:8]  = tm[3:0];
    w[4]     = sq[0];
    w[1:0]   = sz[1:0];
    e = w & 32'h00FF_0F13;
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    m_lim = lim & 8'hFF; m_time = tm & 4'hF; m_seq = sq & 1; m_size = sz & 3;
    m_open = 1'b0;
    chk(cfg_q == e, "R2 cfg readback", cfg_q, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one read; tag names the requirement the hit decision exercises
  task automatic rd(input logic [ADDR_W-1:0] a, input int unsigned lat, input bit en,
                    input string tag);
    int acc_cyc;
    bit eh;
    int ew;
    int n;
    @(negedge clk);
    page_en = en;
    miss_lat = LAT_W'(lat);
    req_valid = 1'b1;
    req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    acc_cyc = cyc;
    eh = model_hit(a, en, acc_cyc);
    if (eh) ew = (m_time < 2) ? 1 : int'(m_time);
    else ew = (LAT_W'(lat) == 0) ? 1 : int'(LAT_W'(lat));
    m_last = a;
    if (!eh) begin
      m_open = en && (m_lim != 0);
      m_open_cyc = acc_cyc;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", req_ready, 0);
    n = 1;
    while (!rsp_done && n < 64) begin
      @(negedge clk);
      n++;
    end
    chk(n == ew, "R10 done timing", n, ew);
    chk(rsp_hit == eh, tag, rsp_hit, eh);
    chk(int'(rsp_wait) == ew, eh ? "R5 hit wait" : "R6 miss wait", rsp_wait, ew);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R10 done single pulse", rsp_done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] base;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; page_en = 1'b1;
    miss_lat = '0; req_valid = 1'b0; req_addr = '0;
    m_lim = 0; m_time = 15; m_seq = 0; m_size = 0; m_open = 0; m_last = '0; m_open_cyc = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk(cfg_q == 32'h0000_0F00, "R1 reset cfg", cfg_q, 32'h0F00);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(rsp_done == 1'b0, "R1 reset done", rsp_done, 0);

    // R8: window 0 makes everything a miss
    rd(10'h040, 3, 1, "R8 window zero");
    rd(10'h041, 3, 1, "R8 window zero");

    // R3 any-word rule, 4-word pages; R5 code 0 gives 1; R6 zero latency clamp
    wr_cfg(20, 0, 0, 0);
    rd(10'h040, 0, 1, "R11 miss opens");
    rd(10'h043, 7, 1, "R3 same page");
    rd(10'h041, 7, 1, "R3 any word");
    rd(10'h044, 7, 1, "R3 page edge");
    wr_cfg(20, 1, 0, 1);
    rd(10'h080, 31, 1, "R11 miss opens");
    rd(10'h087, 31, 1, "R3 8-word page");
    wr_cfg(20, 7, 0, 3);
    rd(10'h100, 2, 1, "R11 miss opens");
    rd(10'h11F, 2, 1, "R3 32-word page");
    rd(10'h120, 2, 1, "R3 page edge");
    // R4 sequential rule
    wr_cfg(40, 2, 1, 3);
    rd(10'h200, 4, 1, "R4 open");
    rd(10'h201, 4, 1, "R4 next word");
    rd(10'h203, 4, 1, "R4 skip misses");
    rd(10'h204, 4, 1, "R4 next word");
    rd(10'h204, 4, 1, "R4 repeat misses");
    rd(10'h21F, 4, 1, "R4 open");
    rd(10'h220, 4, 1, "R4 crosses page");
    // R7 window edge; gap between back-to-back accepts with wait 1 is 3 edges
    wr_cfg(3, 1, 0, 2);
    rd(10'h300, 1, 1, "R7 open");
    rd(10'h301, 1, 1, "R7 inside window");
    wr_cfg(2, 1, 0, 2);
    rd(10'h300, 1, 1, "R7 open");
    rd(10'h301, 1, 1, "R7 past window");
    // R11 hit does not restart the window
    wr_cfg(5, 1, 0, 2);
    rd(10'h300, 1, 1, "R11 open");
    rd(10'h302, 1, 1, "R11 first hit");
    rd(10'h303, 1, 1, "R11 window not restarted");
    // R8 page_en low
    wr_cfg(50, 3, 0, 3);
    rd(10'h000, 5, 1, "R8 open");
    rd(10'h001, 5, 0, "R8 enable low");
    rd(10'h002, 5, 1, "R8 page closed");
    rd(10'h003, 5, 1, "R8 reopened hit");
    // R9 configuration write closes page
    wr_cfg(50, 3, 0, 3);
    rd(10'h004, 5, 1, "R9 closed by write");

    // constrained random mix
    base = 10'h180;
    for (int k = 0; k < 300; k++) begin
      int unsigned r;
      r = $urandom_range(0, 19);
      if (r == 0)
        wr_cfg($urandom_range(0, 12), $urandom_range(0, 15), $urandom_range(0, 1),
               $urandom_range(0, 3));
      if (r == 1) base = ADDR_W'($urandom());
      idle($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0)
        rd(m_last + ADDR_W'(1), $urandom_range(0, 31), ($urandom_range(0, 15) != 0),
           "R7 random sequential");
      else
        rd(base + ADDR_W'($urandom_range(0, 40)), $urandom_range(0, 31),
           ($urandom_range(0, 15) != 0), "R3 random");
    end
    finish_run();
  end

endmodule